// File: doc/BRIEF.md
# PHY Management Register Bridge

This block turns one 32-bit host register into management-bus transactions with an external PHY. The host writes a register address, a data word and a direction flag in a single access. The bridge then generates the management clock, sends a complete serial management frame to a fixed PHY address of 1, and reports completion by inverting the flag bit. On a read it also places the 16-bit result in the data field of the same register.

The host-side view is small. A write with the flag set pushes the data field to the PHY register, and the flag drops when the frame is done. A write with the flag clear fetches a PHY register, and the flag rises once the data field holds the returned value. The host learns that a transaction has finished by polling the register. Any register write that arrives while a frame is on the wire is dropped.

The management data line is split into an output, an output enable and an input. The pad logic combines these three signals into one open line. During the turnaround and data bits of a read, the bridge releases the line so that the PHY can drive it.

Top module: `phy_mgmt_bridge`

## Requirements
- R1: The host register reads back as {flag[31], zeros[30:21], reg_addr[20:16], data[15:0]}. Bits 30:21 always read zero, and the whole register reads zero after reset.
- R2: An accepted write with bit 31 = 1 sends a frame with opcode bits 01, PHY address 00001, the 5-bit register address, turnaround bits 10 and then the 16 data bits. Every field goes out most significant bit first.
- R3: When a PHY write frame finishes, the flag reads 0 and the data and address fields keep the values that were written.
- R4: An accepted write with bit 31 = 0 sends a read frame with opcode bits 10. When it finishes, the flag reads 1 and bits 15:0 hold the 16 bits sampled from the data input on rising MDC edges during the data phase, first bit in the MSB.
- R5: Every frame starts with 32 ones, followed by the start bits 01.
- R6: MDC stays low while the bridge is idle. While a frame is active, MDC toggles every MDC_HALF_DIV clocks. The data output and its enable change only at the clock edge on which MDC falls.
- R7: A write frame drives all 64 bits. A read frame drives the first 46 bits and releases the line (enable low) for the 2 turnaround bits and the 16 data bits.
- R8: A register write that arrives while a frame is in progress is ignored. The register contents and the frame in flight are unchanged.
- R9: The flag inverts exactly 128*MDC_HALF_DIV clock cycles after the edge that accepts the host write.
- R10: Reads of the register return its live contents. The cycle after a write is accepted, the register shows the written flag, address and data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| reg_wr | input | 1 | Host write strobe for the management register |
| reg_wdata | input | 32 | Host write data: flag, register address, data |
| reg_rdata | output | 32 | Live contents of the management register |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable (high = bridge drives the line) |
| mdio_i | input | 1 | Management data input from the line |

## Verification
The register contents are due one clock after the accepting edge. The flag inversion is due exactly 128*MDC_HALF_DIV clocks after that edge. The bench drives and samples on the falling system-clock edge, checks that the flag is unchanged one sample before the due cycle and inverted at the due cycle, and checks the register view on the very next sample. A behavioural PHY captures each line bit and enable on rising MDC, drives read bits on falling MDC, and checks the MDC period of 2*MDC_HALF_DIV clocks between consecutive rising edges. The bench sweeps all 32 register addresses in both directions.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

  localparam int FRAME_LEN    = 64;
  localparam int PREAMBLE_LEN = 32;
  localparam int TA_START     = 46;
  localparam int DATA_START   = 48;
  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 5;

  typedef struct packed {
    logic              flag;
    logic [9:0]        zero;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } mgmt_reg_t;

  function automatic logic [FRAME_LEN-1:0] make_frame(
    input logic              is_read,
    input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] regad,
    input logic [DATA_W-1:0] data
  );
    logic [1:0] op;
    logic [1:0] ta;
    logic [DATA_W-1:0] pay;
    op  = is_read ? 2'b10 : 2'b01;
    ta  = is_read ? 2'b11 : 2'b10;
    pay = is_read ? {DATA_W{1'b1}} : data;
    return {{PREAMBLE_LEN{1'b1}}, 2'b01, op, phy, regad, ta, pay};
  endfunction

endpackage

// File: rtl/mdc_clock_gen.sv
module mdc_clock_gen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic mdc,
  output logic rise_stb,
  output logic fall_stb
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          tick;

  assign tick = run && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    mdc_d = mdc_q;
    if (!run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      mdc_d = ~mdc_q;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc      = mdc_q;
  assign rise_stb = tick & ~mdc_q;
  assign fall_stb = tick & mdc_q;
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import phy_mgmt_pkg::*;
#(
  parameter logic [ADDR_W-1:0] PHY_ADDR = 5'd1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_read,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [DATA_W-1:0] start_data,
  input  logic              rise_stb,
  input  logic              fall_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  localparam int BW = $clog2(FRAME_LEN);
  localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_LEN - 1);
  localparam logic [BW-1:0] TA_BIT   = BW'(TA_START);
  localparam logic [BW-1:0] DAT_BIT  = BW'(DATA_START);

  logic                 busy_q, busy_d;
  logic                 rd_q, rd_d;
  logic [BW-1:0]        bit_q, bit_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d;
  logic [DATA_W-1:0]    cap_q, cap_d;
  logic                 last_bit;

  assign last_bit = (bit_q == LAST_BIT);
  assign done     = busy_q && fall_stb && last_bit;

  always_comb begin
    busy_d = busy_q;
    rd_d   = rd_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    cap_d  = cap_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        rd_d   = start_read;
        bit_d  = '0;
        sh_d   = make_frame(start_read, PHY_ADDR, start_addr, start_data);
      end
    end else begin
      if (rise_stb && rd_q && (bit_q >= DAT_BIT)) begin
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      end
      if (fall_stb) begin
        sh_d = {sh_q[FRAME_LEN-2:0], 1'b1};
        if (last_bit) begin
          busy_d = 1'b0;
        end else begin
          bit_d = bit_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      rd_q   <= 1'b0;
      bit_q  <= '0;
      sh_q   <= '1;
      cap_q  <= '0;
    end else begin
      busy_q <= busy_d;
      rd_q   <= rd_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      cap_q  <= cap_d;
    end
  end

  assign busy    = busy_q;
  assign rd_data = cap_q;
  assign mdio_o  = busy_q ? sh_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = busy_q && !(rd_q && (bit_q >= TA_BIT));
endmodule

// File: rtl/mgmt_host_reg.sv
module mgmt_host_reg
  import phy_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rd_result,
  output logic              start,
  output logic              start_read,
  output logic [ADDR_W-1:0] start_addr,
  output logic [DATA_W-1:0] start_data,
  output logic [31:0]       rdata
);
  mgmt_reg_t wv;
  mgmt_reg_t reg_q, reg_d;
  logic      accept;
  logic      unused_rsvd;

  assign wv          = mgmt_reg_t'(wr_data);
  assign unused_rsvd = ^wv.zero;
  assign accept      = wr_en && !busy;

  always_comb begin
    reg_d = reg_q;
    if (accept) begin
      reg_d.flag = wv.flag;
      reg_d.addr = wv.addr;
      reg_d.data = wv.data;
    end else if (done) begin
      if (reg_q.flag) begin
        reg_d.flag = 1'b0;
      end else begin
        reg_d.flag = 1'b1;
        reg_d.data = rd_result;
      end
    end
    reg_d.zero = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_q <= '0;
    end else begin
      reg_q <= reg_d;
    end
  end

  assign start      = accept;
  assign start_read = !wv.flag;
  assign start_addr = wv.addr;
  assign start_data = wv.data;
  assign rdata      = reg_q;
endmodule

// File: rtl/phy_mgmt_bridge.sv
module phy_mgmt_bridge
  import phy_mgmt_pkg::*;
#(
  parameter int                MDC_HALF_DIV = 4,
  parameter logic [ADDR_W-1:0] PHY_ADDR     = 5'd1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic [1:0]        rst_sync;
  logic              rst_core_n;
  logic              eng_busy, eng_done;
  logic              rise_stb, fall_stb;
  logic              st, st_read;
  logic [ADDR_W-1:0] st_addr;
  logic [DATA_W-1:0] st_data, rd_result;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_core_n = rst_sync[1];

  mgmt_host_reg u_reg (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_en      (reg_wr),
    .wr_data    (reg_wdata),
    .busy       (eng_busy),
    .done       (eng_done),
    .rd_result  (rd_result),
    .start      (st),
    .start_read (st_read),
    .start_addr (st_addr),
    .start_data (st_data),
    .rdata      (reg_rdata)
  );

  mdc_clock_gen #(.HALF_DIV(MDC_HALF_DIV)) u_mdc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .run      (eng_busy),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .fall_stb (fall_stb)
  );

  mgmt_frame_engine #(.PHY_ADDR(PHY_ADDR)) u_eng (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .start      (st),
    .start_read (st_read),
    .start_addr (st_addr),
    .start_data (st_data),
    .rise_stb   (rise_stb),
    .fall_stb   (fall_stb),
    .mdio_i     (mdio_i),
    .busy       (eng_busy),
    .done       (eng_done),
    .rd_data    (rd_result),
    .mdio_o     (mdio_o),
    .mdio_oe    (mdio_oe)
  );
endmodule

// File: rtl/phy_mgmt_bridge_chk.sv
module phy_mgmt_bridge_chk #(
  parameter int MDC_HALF_DIV = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] reg_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy
);
  localparam int TOT = 128 * MDC_HALF_DIV;
  localparam int CW  = $clog2(TOT + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_cnt <= '0;
    end else if (!busy) begin
      busy_cnt <= '0;
    end else begin
      busy_cnt <= busy_cnt + 1'b1;
    end
  end

  p_mdc_idle_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  p_mdio_fall_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  p_flag_inverts_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (reg_rdata[31] != $past(reg_rdata[31])));

  p_ignore_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(reg_rdata[20:16]));

  p_frame_cycles_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == CW'(TOT)));

  p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[30:21] == 10'd0);
endmodule

bind phy_mgmt_bridge phy_mgmt_bridge_chk #(.MDC_HALF_DIV(MDC_HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_rdata (reg_rdata),
  .mdc       (mdc),
  .mdio_o    (mdio_o),
  .mdio_oe   (mdio_oe),
  .busy      (eng_busy)
);

// File: tb/tb_phy_mgmt_bridge.sv
`timescale 1ns/1ps
module tb_phy_mgmt_bridge;
  localparam int D   = 3;
  localparam int TOT = 128 * D;

  logic        clk;
  logic        rst_n;
  logic        reg_wr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int failures = 0;

  // behavioural PHY state
  int          phy_idx;
  logic [63:0] cap_frame;
  logic [63:0] cap_oe;
  logic [15:0] resp;
  int          per_err;
  time         last_rise;

  phy_mgmt_bridge #(.MDC_HALF_DIV(D)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .mdio_i(mdio_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge mdc) begin
    if (phy_idx > 0 && (($time - last_rise) != time'(2 * D * 20))) per_err++;
    last_rise = $time;
    cap_frame = {cap_frame[62:0], mdio_o};
    cap_oe    = {cap_oe[62:0], mdio_oe};
    phy_idx++;
  end

  always @(negedge mdc) begin
    if (phy_idx >= 48 && phy_idx <= 63) mdio_i = resp[15 - (phy_idx - 48)];
    else mdio_i = 1'b1;
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_txn(input bit is_wr, input logic [4:0] a,
                         input logic [15:0] wd, input bit poke);
    logic [31:0] wv, pre;
    logic [63:0] exp;
    logic [1:0]  op, ta;
    logic [15:0] exp_data;
    resp      = 16'hA5C3 ^ (16'(a) * 16'h0811);
    phy_idx   = 0;
    per_err   = 0;
    cap_frame = '0;
    cap_oe    = '0;
    mdio_i    = 1'b1;
    wv        = {is_wr, 10'h3FF, a, wd};
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_wdata = wv;
    @(negedge clk);
    reg_wr    = 1'b0;
    pre = {is_wr, 10'd0, a, wd};
    check(reg_rdata == pre, "R10 live view after accept (R1 zero bits)", 64'(reg_rdata), 64'(pre));
    for (int k = 1; k <= TOT; k++) begin
      @(negedge clk);
      if (poke && k == 10) begin
        reg_wr    = 1'b1;
        reg_wdata = ~wv;
      end
      if (poke && k == 11) begin
        reg_wr = 1'b0;
        check(reg_rdata == pre, "R8 write during frame ignored", 64'(reg_rdata), 64'(pre));
      end
      if (k == TOT - 1)
        check(reg_rdata == pre, "R9 no completion before due cycle", 64'(reg_rdata), 64'(pre));
    end
    exp_data = is_wr ? wd : resp;
    exp = {!is_wr, 10'd0, a, exp_data};
    check(reg_rdata == exp[31:0], is_wr ? "R3 write completion" : "R4 read completion",
          64'(reg_rdata), 64'(exp[31:0]));
    op  = is_wr ? 2'b01 : 2'b10;
    ta  = is_wr ? 2'b10 : 2'b11;
    exp = {32'hFFFF_FFFF, 2'b01, op, 5'd1, a, ta, is_wr ? wd : 16'hFFFF};
    if (is_wr)
      check(cap_frame == exp, "R2 R5 write frame bits", cap_frame, exp);
    else
      check(cap_frame[63:18] == exp[63:18], "R4 R5 read frame header", 64'(cap_frame[63:18]),
            64'(exp[63:18]));
    exp = is_wr ? 64'hFFFF_FFFF_FFFF_FFFF : {46'h3FFF_FFFF_FFFF, 18'd0};
    check(cap_oe == exp, "R7 output enable pattern", cap_oe, exp);
    check(phy_idx == 64 && per_err == 0, "R6 MDC edges and period",
          64'(phy_idx), 64'd64);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R6 idle MDC low", 64'({mdc, mdio_oe}), 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_wdata = '0; mdio_i = 1'b1;
    phy_idx = 0; per_err = 0; last_rise = 0; resp = '0;
    cap_frame = '0; cap_oe = '0;
    repeat (3) @(negedge clk);
    check(reg_rdata == 32'd0 && mdc == 1'b0 && mdio_oe == 1'b0, "R1 reset state",
          64'(reg_rdata), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(reg_rdata == 32'd0, "R1 register after reset release", 64'(reg_rdata), 64'd0);
    for (int a = 0; a < 32; a++) begin
      run_txn(1'b1, 5'(a), 16'h8001 ^ (16'(a) * 16'h0421), a[2]);
      run_txn(1'b0, 5'(a), 16'h1234 ^ 16'(a), a[3]);
    end
    run_txn(1'b1, 5'd31, 16'hFFFF, 1'b1);
    run_txn(1'b1, 5'd0, 16'h0000, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule